// File: doc/BRIEF.md
# Sliced Pointer Arithmetic Unit

This block is the arithmetic engine of a small coprocessor that walks tables through 16-bit pointers. It takes two operands and a 2-bit operation select. It can add the operands, subtract the second from the first, or step the first operand up or down by one. It returns the result, a carry flag, and three test flags. The sequencer branches on those flags: result is zero, result is one, and result is above two.

The data path is cut into equal slices. Each slice reports a group generate and a group propagate term. A separate carry network joins the slices. A parameter selects that network: either a slice-to-slice ripple or a flattened lookahead. In its default form the block registers its outputs once, so a result is ready one clock after its operands are presented. That one clock stage fits the intended 100 ns cycle with margin. Operand capture, the pointer store and the bus interface sit outside the block.

Top module: `ptr_alu`

## Requirements
- R1: While `rst_n` is low, the outputs read `result` = 0, `carry_out` = 0, `flag_zero` = 1, `flag_one` = 0 and `flag_gt2` = 0.
- R2: With `op_sel` = 2'b00, `result` is (A + B) mod 2^16 and `carry_out` is bit 16 of the full sum.
- R3: With `op_sel` = 2'b01, `result` is (A − B) mod 2^16 and `carry_out` is 1 exactly when no borrow occurs (A ≥ B unsigned).
- R4: With `op_sel` = 2'b10, `result` is (A + 1) mod 2^16 and `carry_out` is 1 only for A = 0xFFFF. `op_b` has no effect.
- R5: With `op_sel` = 2'b11, `result` is (A − 1) mod 2^16 and `carry_out` is 1 only for A = 0x0000. `op_b` has no effect.
- R6: With the default output register, every output reflects the operands and select sampled at the previous rising clock edge. The outputs hold steady between edges.
- R7: `flag_zero` is 1 exactly when `result` is 0x0000.
- R8: `flag_one` is 1 exactly when `result` is 0x0001.
- R9: `flag_gt2` is 1 exactly when `result`, read unsigned, is 3 or more. For a result of 2, none of the three flags is set.
- R10: A carry that starts in the lowest bit travels across every slice boundary and produces the correct result. An example is (2^k − 1) + 1 for every k.
- R11: At most one of the three test flags is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (A) |
| op_b | input | 16 | Second operand (B), used only by add and subtract |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 increment, 11 decrement |
| result | output | 16 | Arithmetic result |
| carry_out | output | 1 | Carry out, or no-borrow for subtract, or wrap for increment and decrement |
| flag_zero | output | 1 | Result equals zero |
| flag_one | output | 1 | Result equals one |
| flag_gt2 | output | 1 | Result greater than two (unsigned) |

## Verification
A carry can wrap out of the top slice in the same cycle that the result lands on one of the flagged values. Examples are 0xFFFF + 1 giving zero with carry, 0x0000 − 1 raising the wrap, and 0xFFFF + 3 giving two with carry. A sweep over a grid of slice-edge operand values crossed with all four operations produces these coincidences. Each case is judged against plain 17-bit arithmetic, checking the result, the carry and each flag separately. A second window, half a clock after the inputs change, confirms that the registered outputs still show the previous operation.

// File: rtl/ptr_alu_pkg.sv
package ptr_alu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_INC = 2'b10,
      OP_DEC = 2'b11
   } alu_op_e;

   typedef enum int {
      CHAIN_RIPPLE    = 0,
      CHAIN_LOOKAHEAD = 1
   } chain_mode_e;
endpackage

// File: rtl/ptr_alu_prep.sv
module ptr_alu_prep
   import ptr_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] b_eff,
   output logic             cin,
   output logic             wrap_inv
);
   alu_op_e op;
   assign op = alu_op_e'(sel);

   // a_in only sets the width here; the A operand goes to the slices directly
   logic unused_a;
   assign unused_a = ^a_in;

   always_comb begin
      b_eff    = '0;
      cin      = 1'b0;
      wrap_inv = 1'b0;
      unique case (op)
         OP_ADD: begin
            b_eff = b_in;
            cin   = 1'b0;
         end
         OP_SUB: begin
            b_eff = ~b_in;
            cin   = 1'b1;
         end
         OP_INC: begin
            b_eff = '0;
            cin   = 1'b1;
         end
         OP_DEC: begin
            b_eff    = '1;
            cin      = 1'b0;
            wrap_inv = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ptr_alu_slice.sv
module ptr_alu_slice #(
   parameter int SW = 4
) (
   input  logic [SW-1:0] a,
   input  logic [SW-1:0] b,
   input  logic          cin,
   output logic [SW-1:0] sum,
   output logic          grp_g,
   output logic          grp_p
);
   logic [SW:0]   c;
   logic [SW-1:0] bit_g;
   logic [SW-1:0] bit_p;

   assign bit_g = a & b;
   assign bit_p = a ^ b;

   always_comb begin
      c[0] = cin;
      for (int i = 0; i < SW; i++) begin
         sum[i]   = bit_p[i] ^ c[i];
         c[i+1]   = bit_g[i] | (bit_p[i] & c[i]);
      end
   end

   always_comb begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int i = 0; i < SW; i++) begin
         grp_g = bit_g[i] | (bit_p[i] & grp_g);
         grp_p = grp_p & bit_p[i];
      end
   end

   logic unused_top;
   assign unused_top = c[SW];
endmodule

// File: rtl/ptr_alu_chain.sv
module ptr_alu_chain
   import ptr_alu_pkg::*;
#(
   parameter int NS   = 4,
   parameter int MODE = CHAIN_LOOKAHEAD
) (
   input  logic [NS-1:0] g,
   input  logic [NS-1:0] p,
   input  logic          cin,
   output logic [NS:0]   carry
);
   generate
      if (MODE == CHAIN_RIPPLE) begin : g_ripple
         assign carry[0] = cin;
         for (genvar i = 0; i < NS; i++) begin : g_link
            assign carry[i+1] = g[i] | (p[i] & carry[i]);
         end
      end else begin : g_lookahead
         always_comb begin
            carry[0] = cin;
            for (int i = 0; i < NS; i++) begin
               logic term_p;
               logic acc;
               term_p = 1'b1;
               acc    = 1'b0;
               for (int j = i; j >= 0; j--) begin
                  acc    = acc | (term_p & g[j]);
                  term_p = term_p & p[j];
               end
               carry[i+1] = acc | (term_p & cin);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ptr_alu_flags.sv
module ptr_alu_flags #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] res,
   output logic             is_zero,
   output logic             is_one,
   output logic             is_gt2
);
   logic upper_any;
   assign upper_any = |res[WIDTH-1:2];
   assign is_zero   = ~upper_any & ~res[1] & ~res[0];
   assign is_one    = ~upper_any & ~res[1] &  res[0];
   assign is_gt2    =  upper_any | (res[1] & res[0]);
endmodule

// File: rtl/ptr_alu.sv
module ptr_alu
   import ptr_alu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter int SLICE_W    = 4,
   parameter int CARRY_MODE = CHAIN_LOOKAHEAD,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             flag_zero,
   output logic             flag_one,
   output logic             flag_gt2
);
   localparam int NSLICE = WIDTH / SLICE_W;

   generate
      if (WIDTH % SLICE_W != 0) begin : g_chk_div
         $error("ptr_alu: WIDTH must be a multiple of SLICE_W");
      end
      if (SLICE_W < 2) begin : g_chk_sw
         $error("ptr_alu: SLICE_W must be at least 2");
      end
      if (WIDTH < 4) begin : g_chk_w
         $error("ptr_alu: WIDTH must be at least 4");
      end
      if (CARRY_MODE != CHAIN_RIPPLE && CARRY_MODE != CHAIN_LOOKAHEAD) begin : g_chk_mode
         $error("ptr_alu: unknown CARRY_MODE");
      end
   endgenerate

   logic [WIDTH-1:0]  b_eff;
   logic              cin;
   logic              wrap_inv;
   logic [NSLICE-1:0] sl_g;
   logic [NSLICE-1:0] sl_p;
   logic [NSLICE:0]   sl_c;
   logic [WIDTH-1:0]  sum_c;
   logic              cout_c;
   logic              z_c, o_c, g2_c;

   ptr_alu_prep #(.WIDTH(WIDTH)) u_prep (
      .a_in     (op_a),
      .b_in     (op_b),
      .sel      (op_sel),
      .b_eff    (b_eff),
      .cin      (cin),
      .wrap_inv (wrap_inv)
   );

   generate
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
         ptr_alu_slice #(.SW(SLICE_W)) u_slice (
            .a     (op_a [s*SLICE_W +: SLICE_W]),
            .b     (b_eff[s*SLICE_W +: SLICE_W]),
            .cin   (sl_c[s]),
            .sum   (sum_c[s*SLICE_W +: SLICE_W]),
            .grp_g (sl_g[s]),
            .grp_p (sl_p[s])
         );
      end
   endgenerate

   ptr_alu_chain #(.NS(NSLICE), .MODE(CARRY_MODE)) u_chain (
      .g     (sl_g),
      .p     (sl_p),
      .cin   (cin),
      .carry (sl_c)
   );

   assign cout_c = sl_c[NSLICE] ^ wrap_inv;

   ptr_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res     (sum_c),
      .is_zero (z_c),
      .is_one  (o_c),
      .is_gt2  (g2_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result    <= '0;
               carry_out <= 1'b0;
               flag_zero <= 1'b1;
               flag_one  <= 1'b0;
               flag_gt2  <= 1'b0;
            end else begin
               result    <= sum_c;
               carry_out <= cout_c;
               flag_zero <= z_c;
               flag_one  <= o_c;
               flag_gt2  <= g2_c;
            end
         end
      end else begin : g_comb
         assign result    = sum_c;
         assign carry_out = cout_c;
         assign flag_zero = z_c;
         assign flag_one  = o_c;
         assign flag_gt2  = g2_c;
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
      end
   endgenerate
endmodule

// File: rtl/ptr_alu_chk.sv
module ptr_alu_chk #(
   parameter int WIDTH   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [1:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             flag_zero,
   input logic             flag_one,
   input logic             flag_gt2
);
   logic [WIDTH:0]   ref_full;
   logic [WIDTH-1:0] ref_res;
   logic             ref_c;

   always_comb begin
      unique case (op_sel)
         2'b00: begin
            ref_full = {1'b0, op_a} + {1'b0, op_b};
            ref_c    = ref_full[WIDTH];
         end
         2'b01: begin
            ref_full = {1'b0, op_a} - {1'b0, op_b};
            ref_c    = (op_a >= op_b);
         end
         2'b10: begin
            ref_full = {1'b0, op_a} + 1'b1;
            ref_c    = (op_a == '1);
         end
         default: begin
            ref_full = {1'b0, op_a} - 1'b1;
            ref_c    = (op_a == '0);
         end
      endcase
      ref_res = ref_full[WIDTH-1:0];
   end

   logic [WIDTH-1:0] e_res;
   logic             e_c;
   logic [1:0]       e_op;
   logic             e_valid;

   generate
      if (REG_OUT) begin : g_lat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e_res   <= '0;
               e_c     <= 1'b0;
               e_op    <= 2'b00;
               e_valid <= 1'b0;
            end else begin
               e_res   <= ref_res;
               e_c     <= ref_c;
               e_op    <= op_sel;
               e_valid <= 1'b1;
            end
         end
      end else begin : g_now
         assign e_res   = ref_res;
         assign e_c     = ref_c;
         assign e_op    = op_sel;
         assign e_valid = 1'b1;
      end
   endgenerate

   assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_op == 2'b00) |-> (result == e_res && carry_out == e_c));
   assert_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_op == 2'b01) |-> (result == e_res && carry_out == e_c));
   assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_op == 2'b10) |-> (result == e_res && carry_out == e_c));
   assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_op == 2'b11) |-> (result == e_res && carry_out == e_c));
   assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_zero == (result == '0));
   assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_one == (result == WIDTH'(1)));
   assert_two_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (result == WIDTH'(2)) |-> !(flag_zero || flag_one || flag_gt2));
   assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_zero, flag_one, flag_gt2}));
endmodule

bind ptr_alu ptr_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/ptr_alu_test.sv
`timescale 1ns/1ps
module ptr_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [1:0]  op_sel = 2'b00;
   logic [15:0] result;
   logic        carry_out, flag_zero, flag_one, flag_gt2;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] prev_res = '0;
   logic        prev_c = 1'b0;

   always #2.5 clk = ~clk;

   ptr_alu uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .result(result), .carry_out(carry_out),
      .flag_zero(flag_zero), .flag_one(flag_one), .flag_gt2(flag_gt2)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (a=%h b=%h op=%0d)",
                  req, act, exp, op_a, op_b, op_sel);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] op, input string tag);
      logic [16:0] full;
      logic [15:0] er;
      logic        ec;
      string       rq;
      op_a = a; op_b = b; op_sel = op;
      #1;
      chk("R6 hold", {15'd0, result, carry_out}, {15'd0, prev_res, prev_c});
      case (op)
         2'b00: begin full = {1'b0, a} + {1'b0, b}; ec = full[16]; rq = "R2"; end
         2'b01: begin full = {1'b0, a} - {1'b0, b}; ec = (a >= b); rq = "R3"; end
         2'b10: begin full = {1'b0, a} + 17'd1; ec = (a == 16'hFFFF); rq = "R4"; end
         default: begin full = {1'b0, a} - 17'd1; ec = (a == 16'h0000); rq = "R5"; end
      endcase
      er = full[15:0];
      if (tag != "") rq = tag;
      @(negedge clk);
      chk({rq, " result"}, {16'd0, result}, {16'd0, er});
      chk({rq, " carry"}, {31'd0, carry_out}, {31'd0, ec});
      chk("R7 zero", {31'd0, flag_zero}, {31'd0, er == 16'd0});
      chk("R8 one", {31'd0, flag_one}, {31'd0, er == 16'd1});
      chk("R9 gt2", {31'd0, flag_gt2}, {31'd0, er > 16'd2});
      chk("R11 excl", {31'd0, (flag_zero + flag_one + flag_gt2) <= 2'd1}, 32'd1);
      prev_res = er;
      prev_c   = ec;
   endtask

   logic [15:0] grid [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                              16'h000F, 16'h0010, 16'h00FF, 16'h0100,
                              16'h0FFF, 16'h1000, 16'h7FFF, 16'h8000,
                              16'hFFFD, 16'hFFFE, 16'hFFFF, 16'h5A5A};

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 result", {16'd0, result}, 32'd0);
      chk("R1 carry", {31'd0, carry_out}, 32'd0);
      chk("R1 flags", {29'd0, flag_zero, flag_one, flag_gt2}, 32'b100);
      rst_n = 1'b1;
      // slice-edge grid crossed with every operation
      for (int op = 0; op < 4; op++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               apply(grid[i], grid[j], op[1:0], "");
      // carry walking through every slice boundary (R10)
      for (int k = 1; k <= 16; k++) begin
         apply(16'((32'd1 << k) - 1), 16'd1, 2'b00, "R10");
         apply(16'((32'd1 << k) - 1), 16'hAAAA, 2'b10, "R10");
         apply(16'(32'd1 << (k - 1)), 16'd1, 2'b11, "R10");
      end
      // flag boundary cases: result exactly 2 with wrap, result 1 via dec
      apply(16'hFFFF, 16'h0003, 2'b00, "R9");
      apply(16'h0002, 16'h0000, 2'b11, "R8");
      apply(16'h0001, 16'h0001, 2'b01, "R7");
      // pseudo-random operands, B varied under inc and dec (R4, R5)
      for (int n = 0; n < 3000; n++)
         apply(16'($urandom()), 16'($urandom()), 2'($urandom()), "");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule